// File: doc/BRIEF.md
# Hand-Driven Register/ALU Datapath

This block is the execution core of a single-cycle processor with its sequencing left outside. A register file with two read ports and one write port feeds an arithmetic unit; the unit's result goes straight back to the register file as write data. Operand A always comes from the first read port. Operand B comes either from the second read port or from an immediate input, depending on a source-select line.

No control unit is present. Every control value is an input pin: the clock, a synchronous clear, the two read selectors, the write selector, the write enable, the operand-B source select, the operation code and the 64-bit immediate. Driving these pins one clock at a time executes short instruction sequences by hand. Two observation outputs continuously show the temporary registers x5 and x6. A typical sequence is an add-immediate into x5, a load-immediate (x0 plus a constant) into x6, or a register-register subtract.

Top module: `manual_datapath`

## Requirements
- R1: A rising clock edge with `clr_i` high sets every register to zero, and it does so even when a write is requested in the same cycle.
- R2: When `wen_i` is low and `clr_i` is low, clock edges leave all registers unchanged, whatever the other inputs are.
- R3: With `wen_i` high, the edge writes the result only into the register named by `wsel_i`. Writes naming x0 are discarded, and x0 always reads as zero.
- R4: ALU operand A is the register named by `rsel0_i`. Operand B is `imm_i` when `bsrc_imm_i` is 1, and the register named by `rsel1_i` when it is 0.
- R5: Op code 3'b000 gives A+B and op code 3'b001 gives A−B, both modulo 2^64 (for example, 0−1 gives all ones).
- R6: Op code 3'b010 gives the 64-bit product of the low 32 bits of A and the low 32 bits of B; the upper operand halves are ignored.
- R7: Op code 3'b011 shifts A left and op code 3'b100 shifts A right logically (zero fill). The shift distance is the low 6 bits of B.
- R8: Op codes 3'b101, 3'b110 and 3'b111 produce a result of zero.
- R9: `t0_o` always shows register x5 and `t1_o` always shows register x6.
- R10: `imm_i` is used as a full 64-bit value. Adding an immediate of all ones to a zero x5 makes `t0_o` equal 0xFFFFFFFFFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; register updates happen on the rising edge |
| clr_i | input | 1 | Synchronous clear of all registers |
| rsel0_i | input | 5 | Register that drives ALU operand A |
| rsel1_i | input | 5 | Register offered as operand B |
| wsel_i | input | 5 | Destination register for the result |
| wen_i | input | 1 | Write enable |
| bsrc_imm_i | input | 1 | 1: operand B is the immediate; 0: operand B is the second read port |
| op_i | input | 3 | ALU operation code |
| imm_i | input | 64 | Immediate operand, already sign-extended |
| t0_o | output | 64 | Contents of register x5 |
| t1_o | output | 64 | Contents of register x6 |

## Verification
Each operation is driven with a few kinds of operand:
- Small values tell the operations apart.
- Values with the upper 32 bits set show whether the multiply ignores the high halves.
- Shift distances of 64 and above show whether only the low 6 bits are used.
- The top bit set shows whether the right shift fills with zeros.

Runs of the same write with the enable low, with the selector at x0, or with the selector at x7 separate a missing enable gate from a wrong decode. Clearing while a write is requested shows which of the two takes priority.

// File: rtl/dp_pkg.sv
package dp_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'b000,
      OP_SUB = 3'b001,
      OP_MUL = 3'b010,
      OP_SLL = 3'b011,
      OP_SRL = 3'b100
   } alu_op_e;

endpackage

// File: rtl/dp_wdec.sv
// One-hot write decoder gated by an enable; line 0 does not exist.
module dp_wdec #(
   parameter int N    = 32,
   parameter int SELW = $clog2(N)
) (
   input  logic            clk_i,
   input  logic            en_i,
   input  logic [SELW-1:0] sel_i,
   output logic [N-1:1]    hot_o
);

   if (N < 2 || (1 << SELW) != N) begin : g_bad_n
      $error("dp_wdec: N must be a power of two of at least 2");
   end

   for (genvar i = 1; i < N; i++) begin : g_line
      assign hot_o[i] = en_i && (sel_i == SELW'(i));
   end

   // R3
   wdec_onehot_chk: assert property (@(posedge clk_i) $onehot0(hot_o));
   // R2
   wdec_idle_chk: assert property (@(posedge clk_i) !en_i |-> (hot_o == '0));

endmodule

// File: rtl/dp_regfile.sv
// Register file: NREG entries, entry 0 constant zero, two read ports,
// one write port, synchronous clear, two fixed observation taps.
module dp_regfile #(
   parameter int XLEN   = 64,
   parameter int NREG   = 32,
   parameter int TAP0   = 5,
   parameter int TAP1   = 6,
   localparam int SELW  = $clog2(NREG)
) (
   input  logic            clk_i,
   input  logic            clr_i,
   input  logic            wen_i,
   input  logic [SELW-1:0] wsel_i,
   input  logic [XLEN-1:0] wdata_i,
   input  logic [SELW-1:0] rsel0_i,
   input  logic [SELW-1:0] rsel1_i,
   output logic [XLEN-1:0] rdata0_o,
   output logic [XLEN-1:0] rdata1_o,
   output logic [XLEN-1:0] tap0_o,
   output logic [XLEN-1:0] tap1_o
);

   if (TAP0 <= 0 || TAP0 >= NREG || TAP1 <= 0 || TAP1 >= NREG) begin : g_bad_tap
      $error("dp_regfile: observation taps must name writable registers");
   end

   logic [NREG-1:1] hot;
   logic [XLEN-1:0] regs [NREG];

   dp_wdec #(.N(NREG), .SELW(SELW)) u_wdec (
      .clk_i (clk_i),
      .en_i  (wen_i),
      .sel_i (wsel_i),
      .hot_o (hot)
   );

   assign regs[0] = '0;

   for (genvar i = 1; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk_i) begin
         if (clr_i)       regs[i] <= '0;
         else if (hot[i]) regs[i] <= wdata_i;
      end
   end

   assign rdata0_o = regs[rsel0_i];
   assign rdata1_o = regs[rsel1_i];
   assign tap0_o   = regs[TAP0];
   assign tap1_o   = regs[TAP1];

   // R3
   x0_read_zero_chk: assert property (@(posedge clk_i) disable iff (clr_i)
      (rsel0_i == '0) |-> (rdata0_o == '0));

endmodule

// File: rtl/dp_alu.sv
// Combinational ALU: parallel units and a result select.
module dp_alu
   import dp_pkg::*;
#(
   parameter int XLEN         = 64,
   parameter bit MUL_LOW_HALF = 1'b1,
   localparam int HW          = XLEN / 2,
   localparam int SHW         = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  logic [2:0]      op_i,
   output logic [XLEN-1:0] res_o
);

   if (XLEN < 8 || (XLEN % 2) != 0) begin : g_bad_xlen
      $error("dp_alu: XLEN must be even and at least 8");
   end

   logic            is_sub;
   logic [XLEN-1:0] b_adj;
   logic [XLEN-1:0] sum;
   logic [XLEN-1:0] prod;
   logic [XLEN-1:0] shl;
   logic [XLEN-1:0] shr;
   logic [SHW-1:0]  shamt;

   // Subtraction reuses the adder: invert B, carry in one.
   assign is_sub = (op_i == OP_SUB);
   assign b_adj  = is_sub ? ~b_i : b_i;
   assign sum    = a_i + b_adj + XLEN'(is_sub);

   if (MUL_LOW_HALF) begin : g_mul_half
      logic [XLEN-1:0] a_lo;
      logic [XLEN-1:0] b_lo;
      assign a_lo = {{HW{1'b0}}, a_i[HW-1:0]};
      assign b_lo = {{HW{1'b0}}, b_i[HW-1:0]};
      assign prod = a_lo * b_lo;
   end else begin : g_mul_full
      assign prod = a_i * b_i;
   end

   assign shamt = b_i[SHW-1:0];
   assign shl   = a_i << shamt;
   assign shr   = a_i >> shamt;

   always_comb begin
      unique case (op_i)
         OP_ADD, OP_SUB: res_o = sum;
         OP_MUL:         res_o = prod;
         OP_SLL:         res_o = shl;
         OP_SRL:         res_o = shr;
         default:        res_o = '0;
      endcase
   end

   always_comb begin
      if (!$isunknown({a_i, b_i, op_i})) begin
         // R5
         sub_wrap_chk: assert (op_i != OP_SUB || res_o == a_i - b_i);
         // R8
         spare_op_zero_chk: assert (op_i <= 3'd4 || res_o == '0);
      end
   end

endmodule

// File: rtl/manual_datapath.sv
// Top: register file + ALU + operand-B source select, all control from pins.
module manual_datapath
   import dp_pkg::*;
#(
   parameter int XLEN         = 64,
   parameter int NREG         = 32,
   parameter int T0_IDX       = 5,
   parameter int T1_IDX       = 6,
   parameter bit MUL_LOW_HALF = 1'b1,
   localparam int SELW        = $clog2(NREG)
) (
   input  logic            clk_i,
   input  logic            clr_i,
   input  logic [SELW-1:0] rsel0_i,
   input  logic [SELW-1:0] rsel1_i,
   input  logic [SELW-1:0] wsel_i,
   input  logic            wen_i,
   input  logic            bsrc_imm_i,
   input  logic [2:0]      op_i,
   input  logic [XLEN-1:0] imm_i,
   output logic [XLEN-1:0] t0_o,
   output logic [XLEN-1:0] t1_o
);

   if (T0_IDX == T1_IDX) begin : g_bad_taps
      $error("manual_datapath: the two observed registers must differ");
   end

   logic [XLEN-1:0] rd0;
   logic [XLEN-1:0] rd1;
   logic [XLEN-1:0] opb;
   logic [XLEN-1:0] result;

   dp_regfile #(
      .XLEN (XLEN),
      .NREG (NREG),
      .TAP0 (T0_IDX),
      .TAP1 (T1_IDX)
   ) u_rf (
      .clk_i    (clk_i),
      .clr_i    (clr_i),
      .wen_i    (wen_i),
      .wsel_i   (wsel_i),
      .wdata_i  (result),
      .rsel0_i  (rsel0_i),
      .rsel1_i  (rsel1_i),
      .rdata0_o (rd0),
      .rdata1_o (rd1),
      .tap0_o   (t0_o),
      .tap1_o   (t1_o)
   );

   assign opb = bsrc_imm_i ? imm_i : rd1;

   dp_alu #(
      .XLEN         (XLEN),
      .MUL_LOW_HALF (MUL_LOW_HALF)
   ) u_alu (
      .a_i   (rd0),
      .b_i   (opb),
      .op_i  (op_i),
      .res_o (result)
   );

   // R1
   clear_zero_chk: assert property (@(posedge clk_i)
      clr_i |=> (t0_o == '0 && t1_o == '0));
   // R2
   no_write_hold_chk: assert property (@(posedge clk_i) disable iff (clr_i)
      !wen_i |=> ($stable(t0_o) && $stable(t1_o)));
   // R3
   t0_write_chk: assert property (@(posedge clk_i) disable iff (clr_i)
      (wen_i && wsel_i == SELW'(T0_IDX)) |=> (t0_o == $past(result)));
   // R3
   t0_untouched_chk: assert property (@(posedge clk_i) disable iff (clr_i)
      (wsel_i != SELW'(T0_IDX)) |=> $stable(t0_o));
   // R4
   opb_imm_chk: assert property (@(posedge clk_i) disable iff (clr_i)
      (bsrc_imm_i && op_i == OP_ADD && rsel0_i == '0) |-> (result == imm_i));

endmodule

// File: tb/sim_manual_datapath.sv
module sim_manual_datapath;

   logic        clk = 1'b0;
   logic        clr;
   logic [4:0]  rs0, rs1, ws;
   logic        we, bimm;
   logic [2:0]  op;
   logic [63:0] imm;
   logic [63:0] t0, t1;

   int tests = 0;
   int fails = 0;
   logic [63:0] model [32];

   always #10 clk = ~clk;

   manual_datapath u0 (
      .clk_i      (clk),
      .clr_i      (clr),
      .rsel0_i    (rs0),
      .rsel1_i    (rs1),
      .wsel_i     (ws),
      .wen_i      (we),
      .bsrc_imm_i (bimm),
      .op_i       (op),
      .imm_i      (imm),
      .t0_o       (t0),
      .t1_o       (t1)
   );

   function automatic logic [63:0] ref_alu(logic [63:0] a, logic [63:0] b, logic [2:0] code);
      longint unsigned ua = a, ub = b;
      case (code)
         3'd0: return ua + ub;
         3'd1: return ua - ub;
         3'd2: return (ua % 64'h1_0000_0000) * (ub % 64'h1_0000_0000);
         3'd3: return ua << (ub % 64);
         3'd4: return ua >> (ub % 64);
         default: return 64'd0;
      endcase
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // Apply one cycle of control, update the reference model at the edge,
   // then compare both observed registers against it.
   task automatic step(string tag, logic c, logic [4:0] a0, logic [4:0] a1,
                       logic [4:0] w, logic e, logic bi, logic [2:0] o,
                       logic [63:0] im);
      logic [63:0] opb, res;
      clr = c; rs0 = a0; rs1 = a1; ws = w; we = e; bimm = bi; op = o; imm = im;
      @(posedge clk);
      opb = bi ? im : model[a1];
      res = ref_alu(model[a0], opb, o);
      if (c) begin
         for (int i = 0; i < 32; i++) model[i] = 64'd0;
      end else if (e && w != 5'd0) begin
         model[w] = res;
      end
      #5;
      check({tag, " t0"}, t0, model[5]);
      check({tag, " t1"}, t1, model[6]);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) model[i] = 64'd0;
      clr = 1'b1; rs0 = '0; rs1 = '0; ws = '0; we = 1'b0; bimm = 1'b0; op = '0; imm = '0;
      @(negedge clk);
      // R1: clear wins over a same-cycle write
      step("R1 clear", 1, 0, 0, 5, 1, 1, 3'd0, 64'd9);
      check("R1 reset t0", t0, 64'd0);
      // R4 R9: x5 = x5 + 1
      step("R4 addi x5", 0, 5, 0, 5, 1, 1, 3'd0, 64'd1);
      check("R9 t0 is x5", t0, 64'd1);
      // R9: x6 = x0 + 2
      step("R9 li x6", 0, 0, 0, 6, 1, 1, 3'd0, 64'd2);
      check("R9 t1 is x6", t1, 64'd2);
      // R2: enable low, many edges
      step("R2 hold a", 0, 5, 6, 5, 0, 1, 3'd0, 64'd77);
      step("R2 hold b", 0, 6, 5, 6, 0, 0, 3'd2, 64'd3);
      check("R2 t0 held", t0, 64'd1);
      // R3: write to x0 discarded, then copy x0 into x6
      step("R3 write x0", 0, 0, 0, 0, 1, 1, 3'd0, 64'd55);
      step("R3 read x0", 0, 0, 0, 6, 1, 1, 3'd0, 64'd0);
      check("R3 x0 zero", t1, 64'd0);
      // R3: write x7 leaves taps alone, then copy x7 to x5 via port 1
      step("R3 write x7", 0, 0, 0, 7, 1, 1, 3'd0, 64'h1234);
      step("R3 x7 to x5", 0, 0, 7, 5, 1, 0, 3'd0, 64'd0);
      check("R3 R4 x7 via port1", t0, 64'h1234);
      // R10: -1 immediate
      step("R1 clear2", 1, 0, 0, 0, 0, 0, 3'd0, 64'd0);
      step("R10 addi -1", 0, 5, 0, 5, 1, 1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
      check("R10 all ones", t0, 64'hFFFF_FFFF_FFFF_FFFF);
      // R5: 1 - 1 from registers, then 0 - 1 wraps
      step("R1 clear3", 1, 0, 0, 0, 0, 0, 3'd0, 64'd0);
      step("R5 li x5", 0, 0, 0, 5, 1, 1, 3'd0, 64'd1);
      step("R5 li x6", 0, 0, 0, 6, 1, 1, 3'd0, 64'd1);
      step("R5 sub", 0, 5, 6, 5, 1, 0, 3'd1, 64'd0);
      check("R5 sub zero", t0, 64'd0);
      step("R5 sub wrap", 0, 5, 6, 5, 1, 0, 3'd1, 64'd0);
      check("R5 wrap", t0, 64'hFFFF_FFFF_FFFF_FFFF);
      step("R5 add imm", 0, 6, 0, 6, 1, 1, 3'd0, 64'h7FFF_FFFF_FFFF_FFFF);
      // R6: high halves ignored
      step("R6 li x5", 0, 0, 0, 5, 1, 1, 3'd0, 64'h0000_0001_0000_0003);
      step("R6 li x6", 0, 0, 0, 6, 1, 1, 3'd0, 64'hFFFF_FFFF_0000_0005);
      step("R6 mul reg", 0, 5, 6, 5, 1, 0, 3'd2, 64'd0);
      check("R6 mul low", t0, 64'd15);
      step("R6 li x5 b", 0, 0, 0, 5, 1, 1, 3'd0, 64'hFFFF_FFFF);
      step("R6 mul imm", 0, 5, 0, 5, 1, 1, 3'd2, 64'hAB00_0000_FFFF_FFFF);
      check("R6 mul max", t0, 64'hFFFF_FFFE_0000_0001);
      // R7: shifts
      step("R7 li x5", 0, 0, 0, 5, 1, 1, 3'd0, 64'd7);
      step("R7 sll", 0, 5, 0, 6, 1, 1, 3'd3, 64'd3);
      check("R7 sll 3", t1, 64'd56);
      step("R7 sll big", 0, 5, 0, 6, 1, 1, 3'd3, 64'd67);
      check("R7 sll low6", t1, 64'd56);
      step("R7 srl", 0, 5, 0, 6, 1, 1, 3'd4, 64'd3);
      check("R7 srl 3", t1, 64'd0);
      step("R7 li top", 0, 0, 0, 5, 1, 1, 3'd0, 64'h8000_0000_0000_0000);
      step("R7 srl 63", 0, 5, 0, 6, 1, 1, 3'd4, 64'd63);
      check("R7 srl zero fill", t1, 64'd1);
      // R8: spare codes give zero
      for (int c = 5; c < 8; c++) begin
         step("R7 li x6", 0, 0, 0, 6, 1, 1, 3'd0, 64'd99);
         step("R8 spare op", 0, 5, 0, 6, 1, 1, 3'(c), 64'd4);
         check("R8 spare zero", t1, 64'd0);
      end
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule